// File: doc/BRIEF.md
# Measurement Cycle Sequencer Controller

This block schedules conversions over a set of sensor channels. Software programs a channel enable mask, a per-channel repeat count and a cycle interval through a register-style write port. On a convert command the block walks the enabled channels from the lowest index upward. It holds a conversion request to the converter for each channel until the programmed number of results has come back, then moves on. Every result goes into a result FIFO together with the index of the channel that produced it, so the host can read a whole batch and still tell the samples apart.

In single-cycle mode each convert command produces exactly one cycle. In continuous mode the block waits a programmed number of clocks after each cycle and then starts the next one by itself. When hibernation is enabled, the block parks in a low-power state after each cycle, with its interval timer frozen. It leaves that state only on a falling edge of the active-low wake input. A data-ready output follows one of three selectable events. A status output reports sticky error and alert flags that the converter returns with each result.

Register map (word address: contents): 0 control (bit 0 continuous mode, bits 2:1 data-ready source, bit 3 hibernate enable, bit 4 write-one clear of the error, alert and overflow flags); 1 channel enable mask, bit n for channel n; 2 cycle interval in clocks (32 bits); 4+n repeat count of channel n.

Top module: `meas_seq_ctrl`

## Requirements
- R1: A cycle requests only the channels whose bit in the enable mask (address 1) is set, in ascending channel order, and every FIFO entry carries the channel index in its upper bits above the 24-bit result.
- R2: A repeat count value n (address 4+channel) yields n+1 consecutive conversions of that channel before the next enabled channel is requested; conv_ch stays stable while a request is pending.
- R3: In single-cycle mode (control bit 0 clear) one convert command runs exactly one cycle; a command during a cycle or with an all-zero mask starts nothing.
- R4: In continuous mode conv_req stays low for exactly interval+1 clocks between the end of one cycle and the start of the next; clearing control bit 0 stops the repetition once the current cycle ends.
- R5: The data-ready source (control bits 2:1) is 0 for every result, 1 for a completed cycle, 2 for the result that makes the FIFO full; drdy is a sticky level cleared by a pop, and a new event in the same clock as a pop keeps it high.
- R6: The FIFO returns entries in arrival order; after a pop of a non-empty FIFO the entry appears on rd_data one clock later and rd_data holds otherwise; fifo_empty is high when no entry is stored.
- R7: A result that arrives while the FIFO holds its full depth (64) is dropped and sets the sticky ovf output; the clear bit (control bit 4) resets it.
- R8: status is high while the error flag or the alert flag is set; each is set by a result returned with conv_err or conv_alert and cleared only by control bit 4.
- R9: With hibernation enabled (control bit 3) the block enters hibernation at the end of each cycle (hib high, no request, convert commands ignored); a falling wake_n edge leaves it, and in continuous mode the next cycle starts interval+1 clocks after the wake edge is sampled.
- R10: Writing an all-zero enable mask during a cycle ends it at the next returned result, which is still stored, and raises no cycle-complete event.
- R11: After reset conv_req, drdy, status, ovf and hib are low and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| conv_cmd | input | 1 | Convert command pulse |
| wake_n | input | 1 | Active-low wake, acts on its falling edge |
| conv_req | output | 1 | Conversion request to the converter, held until the cycle ends |
| conv_ch | output | 2 | Channel to convert |
| conv_done | input | 1 | One-clock pulse: one conversion finished |
| conv_data | input | 24 | Result of the finished conversion |
| conv_err | input | 1 | Diagnostic failure flagged with the result |
| conv_alert | input | 1 | Threshold exceeded flagged with the result |
| rd_pop | input | 1 | Pop one FIFO entry |
| rd_data | output | 26 | Popped entry: channel index above result |
| fifo_empty | output | 1 | FIFO holds no entry |
| drdy | output | 1 | Data ready |
| status | output | 1 | Error or alert flag set |
| ovf | output | 1 | Sticky FIFO overflow |
| hib | output | 1 | Block is hibernating |

## Verification
The sequencer is driven with random enable masks and repeat counts under a converter model that answers after a random delay. Draining the FIFO and comparing channel fields against a computed schedule separates skipping, ordering and repeat-count errors, while the result fields expose lost or reordered entries. Directed runs fill the FIFO to its depth in one cycle and push one more result to tell the full event from overflow, measure the idle gap for two interval values in continuous mode and after a wake edge, and abort a cycle by clearing the mask. Reading data-ready mid-cycle under each source setting tells the three sources apart.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_WAIT, ST_HIB} seq_st_t;
  localparam logic [1:0] DR_EACH  = 2'd0;
  localparam logic [1:0] DR_CYCLE = 2'd1;
  localparam logic [1:0] DR_FULL  = 2'd2;
  localparam int A_CTRL = 0;
  localparam int A_MASK = 1;
  localparam int A_IVL  = 2;
  localparam int A_CNT0 = 4;
endpackage

// File: rtl/mseq_cfg.sv
module mseq_cfg
  import mseq_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 4,
  parameter int IVL_W  = 32,
  parameter int AW     = 8,
  parameter int DW     = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [AW-1:0]           addr,
  input  logic [DW-1:0]           wdata,
  output logic                    cont_mode,
  output logic [1:0]              drdy_sel,
  output logic                    hib_en,
  output logic                    clr_flags,
  output logic [NUM_CH-1:0]       ch_en,
  output logic [IVL_W-1:0]        ivl,
  output logic [NUM_CH*CNT_W-1:0] rep_lim
);
  assign clr_flags = we && (addr == AW'(A_CTRL)) && wdata[4];

  always_ff @(posedge clk) begin
    if (rst) begin
      cont_mode <= 1'b0;
      drdy_sel  <= DR_EACH;
      hib_en    <= 1'b0;
      ch_en     <= '0;
      ivl       <= '0;
    end else if (we) begin
      case (addr)
        AW'(A_CTRL): begin
          cont_mode <= wdata[0];
          drdy_sel  <= wdata[2:1];
          hib_en    <= wdata[3];
        end
        AW'(A_MASK): ch_en <= wdata[NUM_CH-1:0];
        AW'(A_IVL):  ivl   <= wdata[IVL_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cnt
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else if (we && addr == AW'(A_CNT0 + c)) cnt_q <= wdata[CNT_W-1:0];
    end
    assign rep_lim[c*CNT_W +: CNT_W] = cnt_q;
  end
endmodule

// File: rtl/mseq_pick.sv
module mseq_pick #(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic [NUM_CH-1:0] mask,
  input  logic [CH_W:0]     base,
  output logic              found,
  output logic [CH_W-1:0]   idx
);
  // lowest enabled channel at or above base
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (mask[i] && ((CH_W+1)'(i) >= base)) begin
        found = 1'b1;
        idx   = CH_W'(i);
      end
    end
  end
endmodule

// File: rtl/mseq_fifo.sv
module mseq_fifo #(
  parameter int DW    = 26,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          full,
  output logic [AW:0]   level
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          wr_ok, rd_ok;

  assign empty = (level == '0);
  assign full  = (level == (AW+1)'(DEPTH));
  assign wr_ok = wr_en && !full;
  assign rd_ok = rd_en && !empty;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_ok) rd_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (wr_ok) wptr <= wptr + 1'b1;
      if (rd_ok) rptr <= rptr + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/meas_seq_ctrl.sv
module meas_seq_ctrl
  import mseq_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int CNT_W      = 4,
  parameter int IVL_W      = 32,
  parameter int RES_W      = 24,
  parameter int FIFO_DEPTH = 64,
  parameter int AW         = 8,
  parameter int DW         = 32,
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ENT_W     = CH_W + RES_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  input  logic             conv_cmd,
  input  logic             wake_n,
  output logic             conv_req,
  output logic [CH_W-1:0]  conv_ch,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  input  logic             conv_err,
  input  logic             conv_alert,
  input  logic             rd_pop,
  output logic [ENT_W-1:0] rd_data,
  output logic             fifo_empty,
  output logic             drdy,
  output logic             status,
  output logic             ovf,
  output logic             hib
);
  localparam int FA = $clog2(FIFO_DEPTH);
  localparam logic [FA:0] LAST_SLOT = (FA+1)'(FIFO_DEPTH - 1);

  logic                    cont_mode, hib_en, clr_flags;
  logic [1:0]              drdy_sel;
  logic [NUM_CH-1:0]       ch_en;
  logic [IVL_W-1:0]        ivl;
  logic [NUM_CH*CNT_W-1:0] rep_lim_all;

  seq_st_t         state;
  logic [CH_W-1:0] cur_ch;
  logic [CNT_W-1:0] rep;
  logic [IVL_W-1:0] tmr;
  logic            wake_q, err_q, alr_q;

  logic            pk_found;
  logic [CH_W-1:0] pk_idx;
  logic [CH_W:0]   pk_base;
  logic            fifo_full;
  logic [FA:0]     fifo_lvl;
  logic            done_ok, last_rep, ev_cycle, ev_full, drdy_set, wake_fall;

  mseq_cfg #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .IVL_W(IVL_W), .AW(AW), .DW(DW)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .cont_mode(cont_mode), .drdy_sel(drdy_sel), .hib_en(hib_en), .clr_flags(clr_flags),
    .ch_en(ch_en), .ivl(ivl), .rep_lim(rep_lim_all)
  );

  assign pk_base = (state == ST_RUN) ? ({1'b0, cur_ch} + 1'b1) : '0;

  mseq_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
    .mask(ch_en), .base(pk_base), .found(pk_found), .idx(pk_idx)
  );

  assign done_ok  = conv_done && (state == ST_RUN);
  assign last_rep = (rep == rep_lim_all[cur_ch*CNT_W +: CNT_W]);
  assign ev_cycle = done_ok && last_rep && !pk_found && (ch_en != '0);
  assign ev_full  = done_ok && !fifo_full && (fifo_lvl == LAST_SLOT) && !(rd_pop && !fifo_empty);
  assign wake_fall = wake_q && !wake_n;

  always_comb begin
    case (drdy_sel)
      DR_EACH:  drdy_set = done_ok;
      DR_CYCLE: drdy_set = ev_cycle;
      DR_FULL:  drdy_set = ev_full;
      default:  drdy_set = 1'b0;
    endcase
  end

  mseq_fifo #(.DW(ENT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(done_ok), .wr_data({cur_ch, conv_data}),
    .rd_en(rd_pop), .rd_data(rd_data), .empty(fifo_empty), .full(fifo_full), .level(fifo_lvl)
  );

  assign conv_ch = cur_ch;
  assign status  = err_q || alr_q;
  assign hib     = (state == ST_HIB);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cur_ch   <= '0;
      rep      <= '0;
      tmr      <= '0;
      conv_req <= 1'b0;
      wake_q   <= 1'b1;
      drdy     <= 1'b0;
      err_q    <= 1'b0;
      alr_q    <= 1'b0;
      ovf      <= 1'b0;
    end else begin
      wake_q <= wake_n;
      drdy   <= drdy_set || (drdy && !rd_pop);
      err_q  <= (err_q && !clr_flags) || (done_ok && conv_err);
      alr_q  <= (alr_q && !clr_flags) || (done_ok && conv_alert);
      ovf    <= (ovf && !clr_flags) || (done_ok && fifo_full);
      case (state)
        ST_IDLE: if (conv_cmd && pk_found) begin
          state    <= ST_RUN;
          cur_ch   <= pk_idx;
          rep      <= '0;
          conv_req <= 1'b1;
        end
        ST_RUN: if (conv_done) begin
          if (ch_en == '0) begin
            state    <= ST_IDLE;
            rep      <= '0;
            conv_req <= 1'b0;
          end else if (!last_rep) begin
            rep <= rep + 1'b1;
          end else if (pk_found) begin
            cur_ch <= pk_idx;
            rep    <= '0;
          end else begin
            rep      <= '0;
            conv_req <= 1'b0;
            if (hib_en) state <= ST_HIB;
            else if (cont_mode) begin
              state <= ST_WAIT;
              tmr   <= ivl;
            end else state <= ST_IDLE;
          end
        end
        ST_WAIT: if (tmr == '0) begin
          if (cont_mode && pk_found) begin
            state    <= ST_RUN;
            cur_ch   <= pk_idx;
            rep      <= '0;
            conv_req <= 1'b1;
          end else state <= ST_IDLE;
        end else tmr <= tmr - 1'b1;
        ST_HIB: if (wake_fall) begin
          if (cont_mode) begin
            state <= ST_WAIT;
            tmr   <= ivl;
          end else state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mseq_chk.sv
module mseq_chk #(
  parameter int CH_W  = 2,
  parameter int ENT_W = 26
) (
  input logic             clk,
  input logic             rst,
  input logic             conv_req,
  input logic [CH_W-1:0]  conv_ch,
  input logic             conv_done,
  input logic             cfg_we,
  input logic             rd_pop,
  input logic             fifo_empty,
  input logic [ENT_W-1:0] rd_data,
  input logic             status,
  input logic             ovf,
  input logic             hib
);
  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_req && !conv_done) |=> (conv_req && $stable(conv_ch)));

  // R9
  hib_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    hib |-> !conv_req);

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_pop && !fifo_empty) |=> $stable(rd_data));

  // R7
  ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> $past(conv_done));

  // R8
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!conv_done && !cfg_we) |=> $stable(status));
endmodule

bind meas_seq_ctrl mseq_chk #(.CH_W(CH_W), .ENT_W(ENT_W)) u_chk (
  .clk(clk), .rst(rst), .conv_req(conv_req), .conv_ch(conv_ch), .conv_done(conv_done),
  .cfg_we(cfg_we), .rd_pop(rd_pop), .fifo_empty(fifo_empty), .rd_data(rd_data),
  .status(status), .ovf(ovf), .hib(hib)
);

// File: tb/meas_seq_ctrl_test.sv
module meas_seq_ctrl_test;
  localparam int RES_W = 24;
  localparam int ENT_W = 26;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [7:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic conv_cmd = 1'b0, wake_n = 1'b1;
  logic conv_req;
  logic [1:0] conv_ch;
  logic conv_done = 1'b0;
  logic [RES_W-1:0] conv_data = '0;
  logic conv_err = 1'b0, conv_alert = 1'b0;
  logic rd_pop = 1'b0;
  logic [ENT_W-1:0] rd_data;
  logic fifo_empty, drdy, status, ovf, hib;

  int checks = 0, errors = 0;
  int issued = 0, cv_wait = 0;
  bit inj_err = 0, inj_alert = 0, finished = 0;
  int cnt_cfg[4];
  int exp_ch[256];

  always #2 clk = ~clk;

  meas_seq_ctrl uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .conv_cmd(conv_cmd), .wake_n(wake_n), .conv_req(conv_req), .conv_ch(conv_ch),
    .conv_done(conv_done), .conv_data(conv_data), .conv_err(conv_err), .conv_alert(conv_alert),
    .rd_pop(rd_pop), .rd_data(rd_data), .fifo_empty(fifo_empty), .drdy(drdy),
    .status(status), .ovf(ovf), .hib(hib)
  );

  function automatic int dfun(int s);
    return (s * 4951 + 5) & 32'h00FF_FFFF;
  endfunction

  // converter model
  always @(negedge clk) begin
    if (conv_done) begin
      conv_done = 1'b0; conv_err = 1'b0; conv_alert = 1'b0;
    end else if (conv_req && !rst) begin
      if (cv_wait == 0) begin
        conv_done = 1'b1;
        conv_data = RES_W'(dfun(issued));
        conv_err = inj_err; conv_alert = inj_alert;
        issued++;
        cv_wait = $urandom_range(0, 2);
      end else cv_wait--;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(int a, int d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = 8'(a); cfg_wdata = 32'(d);
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic pulse_cmd();
    @(negedge clk); conv_cmd = 1'b1;
    @(negedge clk); conv_cmd = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (conv_req && n < 4000) begin @(negedge clk); n++; end
  endtask

  task automatic wait_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pop_one(output logic [ENT_W-1:0] v);
    @(negedge clk); rd_pop = 1'b1;
    @(negedge clk); rd_pop = 1'b0; v = rd_data;
  endtask

  task automatic set_counts();
    for (int c = 0; c < 4; c++) cfg_write(4 + c, cnt_cfg[c]);
  endtask

  task automatic build_seq(input logic [3:0] m, output int n);
    n = 0;
    for (int c = 0; c < 4; c++)
      if (m[c]) for (int r = 0; r <= cnt_cfg[c]; r++) begin exp_ch[n] = c; n++; end
  endtask

  task automatic drain_check(int n, int b);
    logic [ENT_W-1:0] v;
    for (int k = 0; k < n; k++) begin
      pop_one(v);
      chk("R1/R2 channel field", int'(v[ENT_W-1:RES_W]), exp_ch[k]);
      chk("R6 result order", int'(v[RES_W-1:0]), dfun(b + k));
    end
    chk("R6 empty after drain", int'(fifo_empty), 1);
  endtask

  task automatic drain_count(output int n);
    logic [ENT_W-1:0] v;
    n = 0;
    while (!fifo_empty && n < 100) begin pop_one(v); n++; end
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, b, lc, i0, got;
    logic [3:0] m;
    void'($urandom(32'h5eed));
    wait_cycles(4);
    rst = 1'b0;
    wait_cycles(2);
    // R11 reset state
    chk("R11 conv_req", int'(conv_req), 0);
    chk("R11 drdy", int'(drdy), 0);
    chk("R11 status", int'(status), 0);
    chk("R11 ovf", int'(ovf), 0);
    chk("R11 hib", int'(hib), 0);
    chk("R11 fifo_empty", int'(fifo_empty), 1);

    // R1 R2 R3 R5: random masks and counts, single-cycle, drdy on cycle end
    cfg_write(0, 32'h2);
    for (int it = 0; it < 8; it++) begin
      m = 4'($urandom_range(1, 15));
      for (int c = 0; c < 4; c++) cnt_cfg[c] = $urandom_range(0, 3);
      set_counts();
      cfg_write(1, m);
      build_seq(m, n);
      b = issued;
      pulse_cmd();
      wait_idle();
      chk("R5 drdy after cycle", int'(drdy), 1);
      wait_cycles(30);
      chk("R3 one cycle per command", issued - b, n);
      chk("R3 no restart", int'(conv_req), 0);
      drain_check(n, b);
      chk("R5 drdy cleared by pop", int'(drdy), 0);
    end

    // R3 command while busy ignored; R5 cycle source quiet mid-cycle
    for (int c = 0; c < 4; c++) cnt_cfg[c] = 3;
    set_counts();
    cfg_write(1, 4'hF);
    build_seq(4'hF, n);
    b = issued;
    pulse_cmd();
    while (issued == b) @(negedge clk);
    @(negedge clk);
    chk("R5 cycle source low mid-cycle", int'(drdy), 0);
    pulse_cmd();
    wait_idle();
    wait_cycles(40);
    chk("R3 busy command ignored", issued - b, n);
    chk("R3 idle after cycle", int'(conv_req), 0);
    drain_check(n, b);

    // R3 all-zero mask
    cfg_write(1, 0);
    pulse_cmd();
    wait_cycles(10);
    chk("R3 empty mask no request", int'(conv_req), 0);
    chk("R3 empty mask no result", int'(fifo_empty), 1);

    // R5 source 0: every result
    cfg_write(0, 32'h0);
    cnt_cfg[0] = 1; cnt_cfg[1] = 1;
    set_counts();
    cfg_write(1, 4'h3);
    build_seq(4'h3, n);
    b = issued;
    pulse_cmd();
    while (issued == b) @(negedge clk);
    @(negedge clk);
    chk("R5 each-result drdy mid-cycle", int'(drdy), 1);
    chk("R5 still busy", int'(conv_req), 1);
    wait_idle();
    drain_check(n, b);

    // R5 source 2 and R7 overflow
    cfg_write(0, 32'h4);
    for (int c = 0; c < 4; c++) cnt_cfg[c] = 15;
    set_counts();
    cfg_write(1, 4'hF);
    build_seq(4'hF, n);
    b = issued;
    pulse_cmd();
    while (issued == b) @(negedge clk);
    @(negedge clk);
    chk("R5 full source low mid-cycle", int'(drdy), 0);
    wait_idle();
    wait_cycles(2);
    chk("R5 drdy on full", int'(drdy), 1);
    chk("R7 no overflow at depth", int'(ovf), 0);
    cnt_cfg[0] = 0;
    set_counts();
    cfg_write(1, 4'h1);
    pulse_cmd();
    wait_idle();
    wait_cycles(2);
    chk("R7 overflow sticky", int'(ovf), 1);
    chk("R7 extra result issued", issued - b, 65);
    for (int c = 0; c < 4; c++) cnt_cfg[c] = 15;
    build_seq(4'hF, n);
    drain_check(n, b);
    chk("R7 ovf survives pops", int'(ovf), 1);
    cfg_write(0, 32'h12);
    chk("R7 ovf cleared", int'(ovf), 0);

    // R4 continuous interval
    cnt_cfg[0] = 0;
    set_counts();
    cfg_write(1, 4'h1);
    cfg_write(2, 20);
    cfg_write(0, 32'h3);
    pulse_cmd();
    wait_idle();
    lc = 0;
    while (!conv_req && lc < 1000) begin lc++; @(negedge clk); end
    chk("R4 gap interval 20", lc, 21);
    cfg_write(0, 32'h2);
    wait_idle();
    wait_cycles(60);
    chk("R4 stop after clearing mode", int'(conv_req), 0);
    drain_count(got);
    cfg_write(2, 7);
    cfg_write(0, 32'h3);
    pulse_cmd();
    wait_idle();
    lc = 0;
    while (!conv_req && lc < 1000) begin lc++; @(negedge clk); end
    chk("R4 gap interval 7", lc, 8);
    cfg_write(0, 32'h2);
    wait_idle();
    wait_cycles(30);
    drain_count(got);

    // R9 hibernation
    cfg_write(2, 5);
    cfg_write(0, 32'hB);
    pulse_cmd();
    wait_idle();
    chk("R9 hib after cycle", int'(hib), 1);
    wait_cycles(50);
    chk("R9 no request in hib", int'(conv_req), 0);
    pulse_cmd();
    wait_cycles(10);
    chk("R9 command ignored in hib", int'(conv_req), 0);
    chk("R9 still hib", int'(hib), 1);
    @(negedge clk); wake_n = 1'b0;
    @(negedge clk);
    chk("R9 wake leaves hib", int'(hib), 0);
    lc = 0;
    while (!conv_req && lc < 1000) begin lc++; @(negedge clk); end
    chk("R9 restart after wake", lc, 6);
    wake_n = 1'b1;
    cfg_write(0, 32'h2);
    wait_idle();
    wait_cycles(3);
    @(negedge clk); wake_n = 1'b0;
    @(negedge clk); wake_n = 1'b1;
    wait_cycles(20);
    chk("R9 out of hib", int'(hib), 0);
    drain_count(got);

    // R8 status
    chk("R8 status clear", int'(status), 0);
    inj_err = 1;
    pulse_cmd();
    wait_idle();
    inj_err = 0;
    wait_cycles(2);
    chk("R8 status on error", int'(status), 1);
    cfg_write(0, 32'h12);
    chk("R8 cleared by write", int'(status), 0);
    inj_alert = 1;
    pulse_cmd();
    wait_idle();
    inj_alert = 0;
    wait_cycles(2);
    chk("R8 status on alert", int'(status), 1);
    cfg_write(0, 32'h12);
    chk("R8 alert cleared", int'(status), 0);
    drain_count(got);

    // R10 clearing the mask aborts the cycle
    for (int c = 0; c < 4; c++) cnt_cfg[c] = 3;
    set_counts();
    cfg_write(1, 4'hF);
    b = issued;
    pulse_cmd();
    while (issued - b < 3) @(negedge clk);
    i0 = issued - b;
    cfg_write(1, 0);
    wait_idle();
    wait_cycles(10);
    chk("R10 stopped", int'(conv_req), 0);
    chk("R10 at most one more result", int'((issued - b) <= i0 + 2), 1);
    chk("R10 no cycle event", int'(drdy), 0);
    drain_count(got);
    chk("R10 last result stored", got, issued - b);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule